// File: doc/BRIEF.md
# Multi-Period Phase Difference Meter

This block measures the phase offset between two squared-up logic signals: a reference and the output of a network under test. Both signals are brought into the measurement clock domain through two-flop synchronizers. Edges are found by comparing each synchronized level with a one-cycle-delayed copy of it. After a start pulse, a gate opens on the next reference rising edge. It closes on the reference rising edge that ends the requested number of reference periods, so the gate always spans a whole number of periods. While the gate is open, one counter counts every clock cycle (N1). A second counter counts only the cycles in which the two synchronized signals differ (N2).

At the end of the gate, N1, N2, a lead/lag flag and an overflow flag are latched together and a one-cycle done strobe is raised. The lead/lag flag is the level of the network signal sampled on the closing reference edge. A host can form the phase magnitude as N2/N1 × 180 degrees. A built-in sequential divider also reports it directly in tenths of a degree. If the reference stops toggling, a programmable timeout aborts the run and reports a timeout strobe instead of results.

Top module: `phase_meter_top`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, overflow_o, lead_o and phase_valid_o are 0, and n1_o, n2_o and phase_o are 0.
- R2: A start_i pulse while idle arms a measurement. The gate opens on the next reference rising edge and closes on the K-th reference rising edge after that, where K is periods_i and a value of 0 is treated as 1. n1_o equals the number of clock cycles inside the gate, which is K times the reference period in clock cycles.
- R3: n2_o equals the number of clock cycles inside the gate in which the synchronized reference and the synchronized network signal differ.
- R4: lead_o is the synchronized network level at the closing reference rising edge. A value of 1 means the network output leads or is in phase; a value of 0 means it lags.
- R5: n1_o, n2_o, lead_o and overflow_o update together, in the single cycle in which done_o is high. done_o is high for exactly one cycle per measurement, and the results hold until the next done_o.
- R6: Both counters saturate at 2^CNT_W-1 instead of wrapping. overflow_o is latched as 1 when either counter holds that maximum at the end of the gate.
- R7: If timeout_i clock cycles pass while armed or gated without a reference rising edge, the run is aborted. timeout_o pulses for one cycle, done_o is not raised, and n1_o and n2_o keep their previous values.
- R8: phase_o equals floor(N2 × 1800 / N1), in tenths of a degree. phase_valid_o pulses exactly CNT_W+11 cycles after done_o.
- R9: busy_o is 1 from the cycle after an accepted start until the gate closes or the run aborts. It is 0 whenever done_o or timeout_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| ref_i | input | 1 | Asynchronous reference square wave |
| net_i | input | 1 | Asynchronous network-under-test square wave |
| periods_i | input | PER_W | Number of reference periods in the gate (0 counts as 1) |
| timeout_i | input | TO_W | Maximum clock cycles allowed between reference edges |
| busy_o | output | 1 | Measurement armed or gate open |
| done_o | output | 1 | One-cycle strobe: results are valid |
| timeout_o | output | 1 | One-cycle strobe: run aborted |
| overflow_o | output | 1 | A counter saturated during the last gate |
| lead_o | output | 1 | 1 = network leads or is in phase, 0 = lags |
| n1_o | output | CNT_W | Total clock cycles in the gate |
| n2_o | output | CNT_W | Cycles in the gate where the inputs differ |
| phase_valid_o | output | 1 | One-cycle strobe: phase_o is updated |
| phase_o | output | PH_W | Phase magnitude in tenths of a degree |

## Verification
The bench targets several corner cases:
- **Zero period count.** A design that forgot the zero-to-one mapping would never close the gate, or would close it at once.
- **In-phase and anti-phase inputs.** These give N2 of 0 and N2 equal to N1, which shows a difference counter that is gated wrongly or off by one cycle.
- **Lead and lag.** Both signs are exercised; an inverted or mis-sampled lead/lag flag shows up at once.
- **Long gate with a narrowed counter width.** This forces saturation; a wrapping counter would report a small N1 and a wrong phase.
- **Stalled reference.** This must give a timeout strobe with no done strobe and with the previous results left intact.
- **Divider timing.** The bench checks the divider's exact latency and its flooring.

// File: rtl/phm_pkg.sv
// Shared types and constants for the phase difference meter.
package phm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_GATE = 2'd2
    } gate_st_t;

    // Half turn expressed in tenths of a degree.
    localparam int HALF_TURN_TENTHS = 1800;
    localparam int SCALE_W          = 11;
endpackage

// File: rtl/phm_sync.sv
// Two-flop synchronizer with rising-edge detection for N asynchronous inputs.
// Assumes inputs are slow relative to clk (at least a few clocks per level).
module phm_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] meta_q, sync_q, dly_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_ch
            // Two synchronizing stages plus one delay stage for edge finding.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[g] <= 1'b0;
                    sync_q[g] <= 1'b0;
                    dly_q[g]  <= 1'b0;
                end else begin
                    meta_q[g] <= async_i[g];
                    sync_q[g] <= meta_q[g];
                    dly_q[g]  <= sync_q[g];
                end
            end
            assign level_o[g] = sync_q[g];
            assign rise_o[g]  = sync_q[g] & ~dly_q[g];
        end
    endgenerate
endmodule

// File: rtl/phm_gate_ctrl.sv
// Gate controller. It arms on start, opens the gate on a reference rising edge,
// counts whole periods, closes on the K-th following edge and aborts on a timeout.
// Assumes ref_rise is a one-cycle pulse from a synchronized signal.
module phm_gate_ctrl
    import phm_pkg::*;
#(
    parameter int PER_W = 8,
    parameter int TO_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ref_rise,
    input  logic             net_lvl,
    input  logic [PER_W-1:0] periods_i,
    input  logic [TO_W-1:0]  timeout_i,
    output logic             gate_en_o,
    output logic             clr_o,
    output logic             close_o,
    output logic             abort_o,
    output logic             lead_o,
    output logic             busy_o
);
    gate_st_t         st_q;
    logic [PER_W-1:0] k_q, pcnt_q;
    logic [TO_W-1:0]  tmo_q, timer_q;
    logic             close_c, abort_c, last_c;

    assign clr_o     = (st_q == ST_IDLE) && start_i;
    assign gate_en_o = (st_q == ST_GATE);
    assign busy_o    = (st_q != ST_IDLE);
    assign last_c    = ({1'b0, pcnt_q} + 1'b1) >= {1'b0, k_q};
    assign close_c   = gate_en_o && ref_rise && last_c;
    assign abort_c   = busy_o && !ref_rise && (timer_q >= tmo_q);

    // State, period count and edge-gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            k_q     <= '0;
            pcnt_q  <= '0;
            tmo_q   <= '0;
            timer_q <= '0;
        end else begin
            if (clr_o) begin
                st_q    <= ST_ARM;
                k_q     <= (periods_i == '0) ? PER_W'(1) : periods_i;
                tmo_q   <= timeout_i;
                timer_q <= '0;
                pcnt_q  <= '0;
            end else if (abort_c) begin
                st_q <= ST_IDLE;
            end else if (busy_o) begin
                timer_q <= ref_rise ? '0 : timer_q + 1'b1;
                if (ref_rise) begin
                    if (st_q == ST_ARM) begin
                        st_q   <= ST_GATE;
                        pcnt_q <= '0;
                    end else if (last_c) begin
                        st_q <= ST_IDLE;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
            end
        end
    end

    // Registered close/abort strobes and the lead/lag sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            close_o <= 1'b0;
            abort_o <= 1'b0;
            lead_o  <= 1'b0;
        end else begin
            close_o <= close_c;
            abort_o <= abort_c;
            if (close_c) lead_o <= net_lvl;
        end
    end

    // R2: the gate only ever opens on a reference edge.
    a_r2_gate_opens_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en_o) |-> $past(ref_rise));
    // R7: an abort leaves the controller idle.
    a_r7_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !busy_o);
endmodule

// File: rtl/phm_counters.sv
// Saturating gate counters: total cycles (n1) and XOR-high cycles (n2).
// Assumes clr and gate_en are never high together.
module phm_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             gate_en,
    input  logic             diff_lvl,
    output logic [CNT_W-1:0] n1_o,
    output logic [CNT_W-1:0] n2_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    // Count in the gate, hold at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            n1_o <= '0;
            n2_o <= '0;
        end else if (gate_en) begin
            if (n1_o != MAXV)             n1_o <= n1_o + 1'b1;
            if (diff_lvl && n2_o != MAXV) n2_o <= n2_o + 1'b1;
        end
    end

    assign sat_o = (n1_o == MAXV) || (n2_o == MAXV);

    // R3: the difference count never exceeds the total count.
    a_r3_n2_le_n1: assert property (@(posedge clk) disable iff (!rst_n)
        n2_o <= n1_o);
    // R6: a saturated total count stays saturated until cleared.
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (n1_o == MAXV && !clr) |=> n1_o == MAXV);
endmodule

// File: rtl/phm_divider.sv
// Restoring serial divider: quot = floor(num * 1800 / den), one bit per cycle.
// Latency from load to valid is CNT_W+11 cycles. A zero divisor yields 0.
module phm_divider
    import phm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] num,
    input  logic [CNT_W-1:0] den,
    output logic             valid_o,
    output logic [PH_W-1:0]  quot_o
);
    localparam int DW = CNT_W + SCALE_W;
    localparam int SW = $clog2(DW + 1);

    logic [DW-1:0]    dvd_q;
    logic [CNT_W:0]   rem_q, rem_n;
    logic [CNT_W-1:0] dvr_q;
    logic [SW-1:0]    step_q;
    logic             run_q, ge;
    logic [DW-1:0]    q_next;

    assign rem_n  = {rem_q[CNT_W-1:0], dvd_q[DW-1]};
    assign ge     = rem_n >= {1'b0, dvr_q};
    assign q_next = {dvd_q[DW-2:0], ge};

    // One quotient bit per cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q   <= '0;
            rem_q   <= '0;
            dvr_q   <= '0;
            step_q  <= '0;
            run_q   <= 1'b0;
            valid_o <= 1'b0;
            quot_o  <= '0;
        end else if (load) begin
            dvd_q   <= DW'(num) * DW'(HALF_TURN_TENTHS);
            rem_q   <= '0;
            dvr_q   <= den;
            step_q  <= '0;
            run_q   <= 1'b1;
            valid_o <= 1'b0;
        end else if (run_q) begin
            dvd_q  <= q_next;
            rem_q  <= ge ? rem_n - {1'b0, dvr_q} : rem_n;
            step_q <= step_q + 1'b1;
            if (step_q == SW'(DW - 1)) begin
                run_q   <= 1'b0;
                valid_o <= 1'b1;
                quot_o  <= (dvr_q == '0) ? '0 : q_next[PH_W-1:0];
            end
        end else begin
            valid_o <= 1'b0;
        end
    end

    // R8: a magnitude never exceeds half a turn.
    a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> quot_o <= PH_W'(HALF_TURN_TENTHS));
endmodule

// File: rtl/phase_meter_top.sv
// Multi-period phase difference meter top level: synchronizers, gate control,
// gate counters, result latch and an optional tenths-of-degree divider.
// Assumes ref_i and net_i have the same frequency and periods of a few clocks or more.
module phase_meter_top #(
    parameter int CNT_W   = 32,
    parameter int PER_W   = 8,
    parameter int TO_W    = 24,
    parameter int PH_W    = 12,
    parameter bit USE_DIV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ref_i,
    input  logic             net_i,
    input  logic [PER_W-1:0] periods_i,
    input  logic [TO_W-1:0]  timeout_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic             overflow_o,
    output logic             lead_o,
    output logic [CNT_W-1:0] n1_o,
    output logic [CNT_W-1:0] n2_o,
    output logic             phase_valid_o,
    output logic [PH_W-1:0]  phase_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [1:0]       lvl, rise;
    logic             gate_en, clr, close_q, abort_q, lead_s, sat;
    logic [CNT_W-1:0] c1, c2;

    phm_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({net_i, ref_i}),
        .level_o(lvl), .rise_o(rise)
    );

    phm_gate_ctrl #(.PER_W(PER_W), .TO_W(TO_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_rise(rise[0]),
        .net_lvl(lvl[1]), .periods_i(periods_i), .timeout_i(timeout_i),
        .gate_en_o(gate_en), .clr_o(clr), .close_o(close_q), .abort_o(abort_q),
        .lead_o(lead_s), .busy_o(busy_o)
    );

    phm_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .gate_en(gate_en),
        .diff_lvl(lvl[0] ^ lvl[1]), .n1_o(c1), .n2_o(c2), .sat_o(sat)
    );

    // Latch all results together one cycle after the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            timeout_o  <= 1'b0;
            overflow_o <= 1'b0;
            lead_o     <= 1'b0;
            n1_o       <= '0;
            n2_o       <= '0;
        end else begin
            done_o    <= close_q;
            timeout_o <= abort_q;
            if (close_q) begin
                n1_o       <= c1;
                n2_o       <= c2;
                lead_o     <= lead_s;
                overflow_o <= sat;
            end
        end
    end

    generate
        if (USE_DIV) begin : g_div
            phm_divider #(.CNT_W(CNT_W), .PH_W(PH_W)) u_div (
                .clk(clk), .rst_n(rst_n), .load(close_q), .num(c2), .den(c1),
                .valid_o(phase_valid_o), .quot_o(phase_o)
            );
        end else begin : g_nodiv
            assign phase_valid_o = 1'b0;
            assign phase_o       = '0;
        end
    endgenerate

    // R5: the done strobe lasts exactly one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: abort and done are mutually exclusive.
    a_r7_no_done_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));
    // R6: a reported overflow implies a saturated count.
    a_r6_overflow_means_max: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && overflow_o) |-> (n1_o == MAXV || n2_o == MAXV));
    // R9: the block is idle whenever it reports done.
    a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/phase_meter_top_tb_top.sv
module phase_meter_top_tb_top;
    localparam int CW = 12;
    localparam int DW = CW + 11;
    localparam int MAXN = (1 << CW) - 1;

    // Vectors: {period, high time, network delay, periods_i}
    localparam logic [31:0] VEC [0:5] = '{
        {8'd40, 8'd20, 8'd5,  8'd3},
        {8'd40, 8'd20, 8'd35, 8'd2},
        {8'd60, 8'd15, 8'd0,  8'd4},
        {8'd50, 8'd25, 8'd25, 8'd1},
        {8'd33, 8'd10, 8'd7,  8'd0},
        {8'd64, 8'd40, 8'd3,  8'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, ref_i = 1'b0, net_i = 1'b0;
    logic [7:0]  periods_i = '0;
    logic [15:0] timeout_i = '0;
    logic busy_o, done_o, timeout_o, overflow_o, lead_o, phase_valid_o;
    logic [CW-1:0] n1_o, n2_o;
    logic [11:0] phase_o;

    int checks = 0, fails = 0, wd = 0;
    int done_pulses, done_c, ph_c, got_done, got_to, got_ph;
    int busy_start, busy_at_done, busy_at_to;
    longint r_n1, r_n2, r_ph;
    int r_lead, r_ovf;

    always #2 clk = ~clk;

    phase_meter_top #(.CNT_W(CW), .PER_W(8), .TO_W(16), .PH_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_i(ref_i), .net_i(net_i),
        .periods_i(periods_i), .timeout_i(timeout_i), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o), .overflow_o(overflow_o),
        .lead_o(lead_o), .n1_o(n1_o), .n2_o(n2_o),
        .phase_valid_o(phase_valid_o), .phase_o(phase_o)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL R9 watchdog: actual still running, expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_meas(input int P, input int H, input int S, input int K, input int TO);
        int ph = 0;
        done_pulses = 0; got_done = 0; got_to = 0; got_ph = 0;
        busy_start = 0; busy_at_done = 1; busy_at_to = 1; done_c = 0; ph_c = 0;
        periods_i = K[7:0];
        timeout_i = TO[15:0];
        for (int c = 0; c < 12000; c++) begin
            @(negedge clk);
            if (c == 1) busy_start = busy_o;
            if (done_o) begin
                done_pulses++;
                if (!got_done) begin
                    r_n1 = n1_o; r_n2 = n2_o; r_lead = lead_o; r_ovf = overflow_o;
                    busy_at_done = busy_o; done_c = c;
                end
                got_done = 1;
            end
            if (timeout_o) begin got_to = 1; busy_at_to = busy_o; end
            if (phase_valid_o) begin got_ph = 1; r_ph = phase_o; ph_c = c; end
            if (got_ph || got_to) break;
            start_i = (c == 0);
            ref_i = (ph < H);
            net_i = (((ph + P - S) % P) < H);
            ph = (ph + 1) % P;
        end
        start_i = 1'b0;
    endtask

    task automatic check_vec(input int P, input int H, input int S, input int K, input string tag);
        int keff = (K == 0) ? 1 : K;
        longint e_n1, e_n2, e_ph;
        int per2 = 0, e_lead, e_ovf;
        for (int p = 0; p < P; p++) per2 += int'((p < H) ^ (((p + P - S) % P) < H));
        e_n1 = longint'(keff) * P;
        e_n2 = longint'(keff) * per2;
        if (e_n1 > MAXN) e_n1 = MAXN;
        if (e_n2 > MAXN) e_n2 = MAXN;
        e_ovf = (e_n1 == MAXN || e_n2 == MAXN);
        e_lead = (((P - S) % P) < H);
        e_ph = (e_n2 * 1800) / e_n1;
        run_meas(P, H, S, K, 1000);
        chk({"R2 done seen ", tag}, got_done == 1, got_done, 1);
        chk({"R2 n1 ", tag}, r_n1 == e_n1, r_n1, e_n1);
        chk({"R3 n2 ", tag}, r_n2 == e_n2, r_n2, e_n2);
        chk({"R4 lead ", tag}, r_lead == e_lead, r_lead, e_lead);
        chk({"R6 overflow ", tag}, r_ovf == e_ovf, r_ovf, e_ovf);
        chk({"R5 single done ", tag}, done_pulses == 1, done_pulses, 1);
        chk({"R9 busy after start ", tag}, busy_start == 1, busy_start, 1);
        chk({"R9 idle at done ", tag}, busy_at_done == 0, busy_at_done, 0);
        chk({"R8 phase ", tag}, got_ph == 1 && r_ph == e_ph, r_ph, e_ph);
        chk({"R8 latency ", tag}, (ph_c - done_c) == DW, ph_c - done_c, DW);
        chk({"R7 no timeout ", tag}, got_to == 0, got_to, 0);
    endtask

    initial begin
        longint prev_n1, prev_n2;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy_o == 0, busy_o, 0);
        chk("R1 strobes", {done_o, timeout_o, phase_valid_o} == 0, {done_o, timeout_o, phase_valid_o}, 0);
        chk("R1 flags", {overflow_o, lead_o} == 0, {overflow_o, lead_o}, 0);
        chk("R1 counts", n1_o == 0 && n2_o == 0 && phase_o == 0, n1_o + n2_o + phase_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: lag, lead, in phase, anti-phase, zero periods (R2), long gate
        for (int i = 0; i < 6; i++) begin
            check_vec(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]),
                      int'(VEC[i][7:0]), $sformatf("vec%0d", i));
            repeat (3) @(negedge clk);
        end

        // R6: saturation of the total count over a long gate
        check_vec(100, 50, 10, 50, "saturate");
        repeat (3) @(negedge clk);

        // R7: stalled reference aborts with no result update
        prev_n1 = n1_o; prev_n2 = n2_o;
        run_meas(40, 0, 0, 2, 50);
        chk("R7 timeout strobe", got_to == 1, got_to, 1);
        chk("R7 no done", got_done == 0, got_done, 0);
        chk("R7 n1 kept", n1_o == prev_n1, n1_o, prev_n1);
        chk("R7 n2 kept", n2_o == prev_n2, n2_o, prev_n2);
        chk("R9 idle at timeout", busy_at_to == 0, busy_at_to, 0);
        repeat (3) @(negedge clk);

        // R2: a normal run works after an abort
        check_vec(40, 20, 5, 3, "after_abort");

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule